// File: doc/BRIEF.md
# Direct-Mapped Line Cache Controller

This block sits between a processor that issues single 32-bit word reads and writes and a main memory that moves whole 16-byte lines. It keeps one line per index position, with a tag, a valid bit and a dirty bit for each position. Read hits are answered combinationally in the request cycle. On a read miss the whole aligned line is fetched and installed. If the line being displaced holds modified data, it is first written back in full.

A build-time parameter fixes how writes are handled. In no-write mode a write goes only to memory, and a cached copy of the target line is discarded. In write-through mode a write goes to memory, and a cached copy is updated in the same step. In write-back mode a write stays in the cache and marks the line dirty; a write miss first brings the line in. The processor holds its request steady until the one-cycle ready pulse. The memory side uses a request/acknowledge handshake that tolerates any number of wait cycles.

Top module: `cache_ctrl`

## Requirements
- R1: The byte address splits into byte offset [3:0], word select [3:2], line index [15:4] and tag [31:16]. Two addresses with equal [15:4] and different [31:16] compete for the same line and displace each other.
- R2: Reset clears every valid bit. While reset is held and no request is pending, cpu_ready and mem_req are low. The first read of any address after reset is a miss.
- R3: A read miss issues a line read (mem_we=0) at the request address with bits [3:0] forced to zero. The returned line is installed with its tag and valid bit set. The read completes in the cycle after mem_ack with the addressed word of that line.
- R4: A read whose index selects a valid line with a matching tag returns the addressed word with cpu_ready high in the request cycle, and it causes no memory request.
- R5: In no-write mode, a write sends one word to memory (mem_we=1, mem_wmask bit k set for word k = address [3:2], word k on mem_wline bits [32k+31:32k]). If the line was cached, it is invalidated, so the next read of it misses and returns the written value.
- R6: In write-through mode, a write hit writes the word to memory and to the cached line. A later read of it hits and returns the new value.
- R7: In write-back mode, a write hit completes in the request cycle, changes only the cached word, sets the line's dirty bit and sends nothing to memory.
- R8: Before a dirty line is replaced, the whole line is written to memory at its own tag and index, with mem_wmask all ones. This happens before the fill read is issued. A clean line is replaced without any memory write.
- R9: In no-write and write-through modes, a write miss writes the word to memory and does not fetch the line, so a following read of that address misses.
- R10: In write-back mode, a write miss evicts the line if it is dirty, fetches the target line, and then writes the word into it and marks it dirty.
- R11: mem_req stays high with mem_addr and mem_we unchanged until a one-cycle mem_ack, for any number of wait cycles.
- R12: cpu_ready stays low while an eviction, fill or memory word write is in progress. A memory word write in no-write or write-through mode completes in the cycle mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wmask | output | 4 | Word enables for a write, bit k for word k |
| mem_wline | output | 128 | Write line data, word k at bits [32k+31:32k] |
| mem_rline | input | 128 | Read line data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion from memory |

## Verification
A corrupted tag or valid bit shows up at once as the wrong hit/miss outcome. An expected hit that waits for a fill, or an expected miss that answers in the request cycle, is visible on cpu_ready within the same access. A lost dirty bit does not appear until that line is evicted: the old value then comes back after the conflicting line is replaced, one full evict-and-refill sequence later. So the stimulus writes a line, forces it out with a conflicting tag and reads it back, and it counts the memory reads and writes behind each access to catch extra or missing transfers.

// File: rtl/cache_pkg.sv
// Shared types for the line cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cache_pkg;

    // Write-handling variant chosen at build time.
    typedef enum logic [1:0] {
        WP_NONE    = 2'd0,
        WP_THROUGH = 2'd1,
        WP_BACK    = 2'd2
    } wpol_e;

    // Controller sequence states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WORD  = 2'd3
    } cstate_e;

endpackage

// File: rtl/cache_tag_store.sv
// Per-line bookkeeping: tag, valid and dirty bit for each index position.
// Looks up the addressed position combinationally and reports hit and
// victim state. Assumes at most one update per cycle from the sequencer.
module cache_tag_store #(
    parameter int INDEX_W = 12,
    parameter int TAG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic               fill_en,
    input  logic               inval,
    input  logic               dirty_set,
    input  logic               dirty_clr,
    output logic               hit,
    output logic               vic_valid,
    output logic               vic_dirty,
    output logic [TAG_W-1:0]   vic_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: cleared on reset, set by a fill, cleared by invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[lk_index] <= 1'b1;
        end else if (inval) begin
            valid_q[lk_index] <= 1'b0;
        end
    end

    // Dirty bits: a fill or a completed write-back leaves the line clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (fill_en || dirty_clr) begin
            dirty_q[lk_index] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[lk_index] <= 1'b1;
        end
    end

    // Tag storage: written only when a new line is installed.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[lk_index] <= lk_tag;
        end
    end

    // Lookup of the addressed position.
    always_comb begin
        vic_valid = valid_q[lk_index];
        vic_dirty = dirty_q[lk_index];
        vic_tag   = tag_q[lk_index];
        hit       = vic_valid && (vic_tag == lk_tag);
    end

endmodule

// File: rtl/cache_data_store.sv
// Line data array. Reads the addressed line combinationally and picks one
// word from it. Takes either a whole-line write (fill) or a single-word
// write per cycle; the line write wins if both are raised.
module cache_data_store #(
    parameter int INDEX_W    = 12,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32
) (
    input  logic                         clk,
    input  logic [INDEX_W-1:0]           index,
    input  logic [$clog2(LINE_WORDS)-1:0] wsel,
    input  logic                         line_we,
    input  logic [LINE_WORDS*WORD_W-1:0] line_wdata,
    input  logic                         word_we,
    input  logic [WORD_W-1:0]            word_wdata,
    output logic [LINE_WORDS*WORD_W-1:0] line_rdata,
    output logic [WORD_W-1:0]            word_rdata
);
    localparam int LINES  = 1 << INDEX_W;
    localparam int LINE_W = LINE_WORDS * WORD_W;

    logic [LINE_W-1:0] mem_q [LINES];
    logic [WORD_W-1:0] words [LINE_WORDS];

    // Array write: full line on fill, one word on a cached write.
    always_ff @(posedge clk) begin
        if (line_we) begin
            mem_q[index] <= line_wdata;
        end else if (word_we) begin
            mem_q[index][wsel*WORD_W +: WORD_W] <= word_wdata;
        end
    end

    assign line_rdata = mem_q[index];

    // Split the addressed line into words for the select mux.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign words[w] = line_rdata[w*WORD_W +: WORD_W];
    end

    assign word_rdata = words[wsel];

endmodule

// File: rtl/cache_ctrl_fsm.sv
// Sequencer for hits, evictions, fills and memory word writes.
// The write-handling variant is fixed by POLICY. Assumes the processor
// holds its request fields stable until cpu_ready, and memory pulses
// mem_ack for one cycle per transfer.
module cache_ctrl_fsm
    import cache_pkg::*;
#(
    parameter wpol_e POLICY = WP_BACK
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req,
    input  logic    cpu_we,
    input  logic    hit,
    input  logic    vic_valid,
    input  logic    vic_dirty,
    input  logic    mem_ack,
    output cstate_e state,
    output logic    cpu_ready,
    output logic    mem_req,
    output logic    mem_we,
    output logic    fill_en,
    output logic    inval,
    output logic    dirty_set,
    output logic    dirty_clr,
    output logic    word_we
);
    // Derived policy flags.
    localparam bit ALLOC_ON_WRITE = (POLICY == WP_BACK);
    localparam bit KEEP_ON_WRITE  = (POLICY == WP_THROUGH);

    cstate_e st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and per-cycle controls.
    always_comb begin
        st_d      = st_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        inval     = 1'b0;
        dirty_set = 1'b0;
        dirty_clr = 1'b0;
        word_we   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we && !ALLOC_ON_WRITE) begin
                        st_d = ST_WORD;
                    end else if (hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            word_we   = 1'b1;
                            dirty_set = 1'b1;
                        end
                    end else if (vic_valid && vic_dirty) begin
                        st_d = ST_EVICT;
                    end else begin
                        st_d = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    dirty_clr = 1'b1;
                    st_d      = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    st_d      = ST_IDLE;
                    if (hit) begin
                        word_we = KEEP_ON_WRITE;
                        inval   = !KEEP_ON_WRITE;
                    end
                end
            end
        endcase
    end

    assign state = st_q;

    // Completion is never signalled while a memory transfer is outstanding.
    p_no_ready_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !mem_ack) |-> !cpu_ready);

    // The sequencer always returns to idle after a fill completes.
    p_fill_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL && mem_ack) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/cache_ctrl.sv
// Direct-mapped line cache between a word-wide processor port and a
// line-wide memory port. Combines tag store, data store and sequencer, and
// forms memory addresses, write lines and word masks. Assumes word-aligned
// processor accesses; address bits below the word select are ignored.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int    ADDR_W     = 32,
    parameter int    WORD_W     = 32,
    parameter int    LINE_WORDS = 4,
    parameter int    INDEX_W    = 12,
    parameter wpol_e POLICY     = WP_BACK
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic [WORD_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [LINE_WORDS-1:0]        mem_wmask,
    output logic [LINE_WORDS*WORD_W-1:0] mem_wline,
    input  logic [LINE_WORDS*WORD_W-1:0] mem_rline,
    input  logic                         mem_ack
);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BSEL_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;
    localparam int LINE_W = LINE_WORDS * WORD_W;

    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    logic [WSEL_W-1:0]  wsel;
    logic [BSEL_W-1:0]  unused_bsel;

    logic               hit, vic_valid, vic_dirty;
    logic [TAG_W-1:0]   vic_tag;
    logic               fill_en, inval, dirty_set, dirty_clr, word_we;
    logic [LINE_W-1:0]  line_rdata;
    cstate_e            state;

    assign unused_bsel = cpu_addr[BSEL_W-1:0];
    assign wsel        = cpu_addr[BSEL_W +: WSEL_W];
    assign idx         = cpu_addr[OFF_W +: INDEX_W];
    assign tag         = cpu_addr[ADDR_W-1 -: TAG_W];

    cache_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_index  (idx),
        .lk_tag    (tag),
        .fill_en   (fill_en),
        .inval     (inval),
        .dirty_set (dirty_set),
        .dirty_clr (dirty_clr),
        .hit       (hit),
        .vic_valid (vic_valid),
        .vic_dirty (vic_dirty),
        .vic_tag   (vic_tag)
    );

    cache_data_store #(
        .INDEX_W    (INDEX_W),
        .LINE_WORDS (LINE_WORDS),
        .WORD_W     (WORD_W)
    ) u_data (
        .clk        (clk),
        .index      (idx),
        .wsel       (wsel),
        .line_we    (fill_en),
        .line_wdata (mem_rline),
        .word_we    (word_we),
        .word_wdata (cpu_wdata),
        .line_rdata (line_rdata),
        .word_rdata (cpu_rdata)
    );

    cache_ctrl_fsm #(
        .POLICY (POLICY)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .vic_valid (vic_valid),
        .vic_dirty (vic_dirty),
        .mem_ack   (mem_ack),
        .state     (state),
        .cpu_ready (cpu_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .fill_en   (fill_en),
        .inval     (inval),
        .dirty_set (dirty_set),
        .dirty_clr (dirty_clr),
        .word_we   (word_we)
    );

    // Memory-side address, data and word mask for the current transfer.
    always_comb begin
        mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wline = {LINE_WORDS{cpu_wdata}};
        mem_wmask = '0;
        case (state)
            ST_EVICT: begin
                mem_addr  = {vic_tag, idx, {OFF_W{1'b0}}};
                mem_wline = line_rdata;
                mem_wmask = '1;
            end
            ST_WORD: begin
                mem_wmask = {{(LINE_WORDS-1){1'b0}}, 1'b1} << wsel;
            end
            default: begin
                mem_wmask = '0;
            end
        endcase
    end

    // Memory request fields hold until acknowledged.
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // A line is never overwritten by a fill while it still holds unsaved data.
    p_fill_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !vic_dirty);

    // A completed fill makes the held address hit on the next cycle.
    p_fill_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack) |=> (hit || cpu_addr != $past(cpu_addr)));

    // Variant-specific write checks.
    if (POLICY == WP_BACK) begin : g_wb_chk
        // A cached write leaves the line marked dirty.
        p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_IDLE && cpu_req && cpu_we && hit)
            |=> (vic_dirty || cpu_addr != $past(cpu_addr)));
    end else if (POLICY == WP_NONE) begin : g_nw_chk
        // A memory write to a cached line drops that line.
        p_nw_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WORD && mem_ack && hit)
            |=> (!hit || cpu_addr != $past(cpu_addr)));
    end else begin : g_wt_chk
        // A write-through hit keeps the line cached.
        p_wt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WORD && mem_ack && hit)
            |=> (hit || cpu_addr != $past(cpu_addr)));
    end

endmodule

// File: tb/cache_ctrl_test.sv
`timescale 1ns/1ps

// Line memory with variable latency (2 to 5 cycles), seeded contents and
// transfer counters. Bench-side model only.
module cache_mem_model (
    input  logic         clk,
    input  logic         req,
    input  logic         we,
    input  logic [31:0]  addr,
    input  logic [3:0]   wmask,
    input  logic [127:0] wline,
    output logic [127:0] rline,
    output logic         ack,
    output int           n_rd,
    output int           n_wr,
    output logic [3:0]   last_mask
);
    logic [127:0] store [logic [27:0]];
    logic         busy;
    int           cnt;
    int           seq;
    logic [127:0] ln;

    function automatic logic [31:0] seed_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [127:0] get_line(input logic [27:0] la);
        logic [127:0] r;
        if (store.exists(la)) return store[la];
        for (int k = 0; k < 4; k++) r[32*k +: 32] = seed_word({la, 4'h0} + 32'(4*k));
        return r;
    endfunction

    initial begin
        busy = 0; ack = 0; cnt = 0; seq = 0; n_rd = 0; n_wr = 0;
        last_mask = '0; rline = '0;
    end

    always @(posedge clk) begin
        ack <= 1'b0;
        if (!busy) begin
            if (req && !ack) begin
                busy <= 1'b1;
                cnt  <= seq % 4;
                seq  <= seq + 1;
            end
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end else begin
            busy <= 1'b0;
            ack  <= 1'b1;
            if (we) begin
                ln = get_line(addr[31:4]);
                for (int k = 0; k < 4; k++)
                    if (wmask[k]) ln[32*k +: 32] = wline[32*k +: 32];
                store[addr[31:4]] = ln;
                n_wr      <= n_wr + 1;
                last_mask <= wmask;
            end else begin
                rline <= get_line(addr[31:4]);
                n_rd  <= n_rd + 1;
            end
        end
    end
endmodule

module cache_ctrl_test;
    import cache_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         cpu_req [3];
    logic         cpu_we [3];
    logic [31:0]  cpu_addr [3];
    logic [31:0]  cpu_wdata [3];
    logic [31:0]  cpu_rdata [3];
    logic         cpu_ready [3];
    logic         mem_req [3];
    logic         mem_we [3];
    logic [31:0]  mem_addr [3];
    logic [3:0]   mem_wmask [3];
    logic [127:0] mem_wline [3];
    logic [127:0] mem_rline [3];
    logic         mem_ack [3];
    int           n_rd [3];
    int           n_wr [3];
    logic [3:0]   last_mask [3];

    // Instance 0: write-back, 1: write-through, 2: no-write.
    for (genvar i = 0; i < 3; i++) begin : g_dut
        localparam wpol_e POL = (i == 0) ? WP_BACK : ((i == 1) ? WP_THROUGH : WP_NONE);
        cache_ctrl #(.POLICY(POL)) uut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[i]), .cpu_we(cpu_we[i]), .cpu_addr(cpu_addr[i]),
            .cpu_wdata(cpu_wdata[i]), .cpu_rdata(cpu_rdata[i]), .cpu_ready(cpu_ready[i]),
            .mem_req(mem_req[i]), .mem_we(mem_we[i]), .mem_addr(mem_addr[i]),
            .mem_wmask(mem_wmask[i]), .mem_wline(mem_wline[i]),
            .mem_rline(mem_rline[i]), .mem_ack(mem_ack[i])
        );
        cache_mem_model mdl (
            .clk(clk), .req(mem_req[i]), .we(mem_we[i]), .addr(mem_addr[i]),
            .wmask(mem_wmask[i]), .wline(mem_wline[i]), .rline(mem_rline[i]),
            .ack(mem_ack[i]), .n_rd(n_rd[i]), .n_wr(n_wr[i]), .last_mask(last_mask[i])
        );
    end

    function automatic logic [31:0] seed(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3C3_0000;
    endfunction

    localparam logic [31:0] A  = 32'h1000_800C;
    localparam logic [31:0] A8 = 32'h1000_8008;
    localparam logic [31:0] A4 = 32'h1000_8004;
    localparam logic [31:0] B  = 32'h2000_8004;
    localparam logic [31:0] C  = 32'h0000_0010;
    localparam logic [31:0] D  = 32'h3000_0010;

    typedef struct packed {
        logic [1:0]  m;     // instance
        logic        we;
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] x;     // expected read data
        logic        hit;   // expect completion in the request cycle
        logic [3:0]  dr;    // expected line reads
        logic [3:0]  dw;    // expected memory writes
        logic [3:0]  rq;    // requirement number for messages
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, A,  32'h0,         seed(A),       1'b0, 4'd1, 4'd0, 4'd3},  // R3 first miss
        '{2'd0, 1'b0, A8, 32'h0,         seed(A8),      1'b1, 4'd0, 4'd0, 4'd4},  // R4 hit same line
        '{2'd0, 1'b1, A,  32'hDEAD_0001, 32'h0,         1'b1, 4'd0, 4'd0, 4'd7},  // R7 cached write
        '{2'd0, 1'b0, A,  32'h0,         32'hDEAD_0001, 1'b1, 4'd0, 4'd0, 4'd7},  // R7 read back
        '{2'd0, 1'b0, B,  32'h0,         seed(B),       1'b0, 4'd1, 4'd1, 4'd8},  // R8 R1 dirty evict
        '{2'd0, 1'b0, A,  32'h0,         32'hDEAD_0001, 1'b0, 4'd1, 4'd0, 4'd8},  // R8 clean evict
        '{2'd0, 1'b1, C,  32'h1111_2222, 32'h0,         1'b0, 4'd1, 4'd0, 4'd10}, // R10 allocate
        '{2'd0, 1'b0, C,  32'h0,         32'h1111_2222, 1'b1, 4'd0, 4'd0, 4'd10}, // R10 read back
        '{2'd1, 1'b0, A,  32'h0,         seed(A),       1'b0, 4'd1, 4'd0, 4'd3},  // R3
        '{2'd1, 1'b1, A,  32'hBEEF_0002, 32'h0,         1'b0, 4'd0, 4'd1, 4'd6},  // R6 write hit
        '{2'd1, 1'b0, A,  32'h0,         32'hBEEF_0002, 1'b1, 4'd0, 4'd0, 4'd6},  // R6 still cached
        '{2'd1, 1'b1, C,  32'h3333_4444, 32'h0,         1'b0, 4'd0, 4'd1, 4'd9},  // R9 no allocate
        '{2'd1, 1'b0, C,  32'h0,         32'h3333_4444, 1'b0, 4'd1, 4'd0, 4'd9},  // R9 miss after
        '{2'd2, 1'b0, A,  32'h0,         seed(A),       1'b0, 4'd1, 4'd0, 4'd3},  // R3
        '{2'd2, 1'b1, A,  32'hCAFE_0003, 32'h0,         1'b0, 4'd0, 4'd1, 4'd5},  // R5 write hit
        '{2'd2, 1'b0, A,  32'h0,         32'hCAFE_0003, 1'b0, 4'd1, 4'd0, 4'd5},  // R5 line dropped
        '{2'd2, 1'b0, A4, 32'h0,         seed(A4),      1'b1, 4'd0, 4'd0, 4'd4},  // R4
        '{2'd2, 1'b1, C,  32'h5555_6666, 32'h0,         1'b0, 4'd0, 4'd1, 4'd9},  // R9
        '{2'd2, 1'b0, C,  32'h0,         32'h5555_6666, 1'b0, 4'd1, 4'd0, 4'd9}   // R9
    };

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input int m, input logic we, input logic [31:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req[m] = 1'b1; cpu_we[m] = we; cpu_addr[m] = a; cpu_wdata[m] = d;
        waits = 0;
        #1;
        while (!cpu_ready[m] && waits < 500) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata[m];
        @(negedge clk);
        cpu_req[m] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int          w, r0, w0;
        for (int i = 0; i < 3; i++) begin
            cpu_req[i] = 0; cpu_we[i] = 0; cpu_addr[i] = 0; cpu_wdata[i] = 0;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        for (int i = 0; i < 3; i++) begin
            chk(!cpu_ready[i], "R2", "ready in reset", 32'(cpu_ready[i]), 32'h0);
            chk(!mem_req[i], "R2", "mem_req in reset", 32'(mem_req[i]), 32'h0);
        end
        rst_n = 1'b1;

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            int m;
            m  = int'(VECS[v].m);
            r0 = n_rd[m]; w0 = n_wr[m];
            access(m, VECS[v].we, VECS[v].a, VECS[v].d, rd, w);
            if (!VECS[v].we)
                chk(rd == VECS[v].x, $sformatf("R%0d v%0d", VECS[v].rq, v), "read data", rd, VECS[v].x);
            chk((w == 0) == VECS[v].hit, $sformatf("R%0d/R12 v%0d", VECS[v].rq, v),
                "ready in request cycle", 32'(w == 0), 32'(VECS[v].hit));
            chk(n_rd[m] - r0 == int'(VECS[v].dr), $sformatf("R%0d v%0d", VECS[v].rq, v),
                "line reads", 32'(n_rd[m] - r0), 32'(VECS[v].dr));
            chk(n_wr[m] - w0 == int'(VECS[v].dw), $sformatf("R%0d v%0d", VECS[v].rq, v),
                "memory writes", 32'(n_wr[m] - w0), 32'(VECS[v].dw));
        end

        // R6 R5 word mask: write-through write to word 1 enables only bit 1.
        w0 = n_wr[1];
        access(1, 1'b1, A4, 32'h7777_8888, rd, w);
        chk(last_mask[1] == 4'b0010, "R6", "word write mask", 32'(last_mask[1]), 32'h2);
        chk(n_wr[1] - w0 == 1, "R6", "word write count", 32'(n_wr[1] - w0), 32'h1);
        access(1, 1'b0, A4, 32'h0, rd, w);
        chk(rd == 32'h7777_8888 && w == 0, "R6", "hit after word write", rd, 32'h7777_8888);

        // R8 R10 write miss over a dirty line: full-line write-back first.
        r0 = n_rd[0]; w0 = n_wr[0];
        access(0, 1'b1, D, 32'h9999_AAAA, rd, w);
        chk(last_mask[0] == 4'b1111, "R8", "evict mask", 32'(last_mask[0]), 32'hF);
        chk(n_wr[0] - w0 == 1 && n_rd[0] - r0 == 1, "R10", "evict+fill count",
            32'((n_wr[0] - w0) * 16 + (n_rd[0] - r0)), 32'h11);
        access(0, 1'b0, C, 32'h0, rd, w);
        chk(rd == 32'h1111_2222, "R8", "written-back data refetched", rd, 32'h1111_2222);

        // R2 reset clears valid: a previously cached line misses again.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        r0 = n_rd[0];
        access(0, 1'b0, C, 32'h0, rd, w);
        chk(n_rd[0] - r0 == 1 && w > 0, "R2", "miss after reset", 32'(n_rd[0] - r0), 32'h1);
        chk(rd == 32'h1111_2222, "R2", "data after reset", rd, 32'h1111_2222);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule